// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the data side of a small processor in which every transfer between storage elements crosses one shared internal bus. It contains four general registers, a program counter, an instruction register, a memory address register, a memory data register, an operand latch feeding the arithmetic unit, a scratch register and a result register. An external sequencer supplies one control word per clock cycle. Each field of that word either lets a register place its value on the bus or lets a register capture the bus at the next clock edge. Instruction decoding and step sequencing belong to the controller, not to this block.

The arithmetic unit has no storage of its own. Its first operand is either the operand latch or the constant four, and its second operand is the bus. Its result can only be kept by loading the result register, and it reaches the bus one cycle later when that register is allowed to drive. The memory side presents the address register on the address lines at all times. It passes the read and write strobes straight through from the control word. The data register can swap data with the memory lines, and it captures read data only once the memory reports that the access is complete.

Top module: `sbp_datapath`

## Requirements
- R1: A synchronous active-high reset clears every register. After reset, any single driver puts 0 on the bus and the memory address lines read 0.
- R2: Control bits [26:19] are bus-drive enables, one per source: bit 19+i drives general register i (i = 0..3), bit 23 the program counter, bit 24 the data register, bit 25 the result register and bit 26 the scratch register. With exactly one of these set, the bus carries that source's value in the same cycle. With none set, the bus reads 0.
- R3: If two or more drive enables are set, `bus_conflict` is 1 in that cycle and the bus carries the value of the lowest-numbered set source. Otherwise `bus_conflict` is 0.
- R4: Control bits [18:8] are load enables: bit 8+i loads general register i, bit 12 the program counter, 13 the instruction register, 14 the address register, 15 the data register (from the bus), 16 the operand latch, 17 the result register and 18 the scratch register. An enabled register takes the bus value at the rising clock edge. A register whose enable is clear keeps its value.
- R5: The arithmetic unit's first operand is the constant 4 when bit 4 is 1 and the operand latch when bit 4 is 0. Its second operand is the bus. Bit 5 is the carry input. Bits [7:6] pick the function: 0 gives first+second+carry, 1 gives first-second-carry, 2 gives first XOR second, 3 passes the second operand. Results wrap modulo 2^16.
- R6: The result of R5 is stored only in the result register when bit 17 is set. The result register holds its value in every other cycle.
- R7: The memory address lines always show the address register.
- R8: When bit 3 is set and `mem_mfc` is 1, the data register captures `mem_rdata`, which takes precedence over bit 15. When bit 3 is set and `mem_mfc` is 0, the data register does not capture `mem_rdata`.
- R9: `mem_wdata` shows the data register when bit 2 is 1 and is 0 when bit 2 is 0. `mem_rd` follows bit 1 and `mem_wr` follows bit 0.
- R10: `ir_out` always shows the instruction register.
- R11: A three-step sequence adds general registers 1 and 2 and leaves the sum in general register 3. Step 1 drives register 1 and loads the latch. Step 2 drives register 2 with the add function, latch selected, and loads the result register. Step 3 drives the result register and loads register 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 27 | Control word for the current cycle |
| mem_rdata | input | 16 | Read data from memory |
| mem_mfc | input | 1 | Memory reports that the access is complete |
| mem_addr | output | 16 | Address register contents |
| mem_wdata | output | 16 | Write data toward memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| ir_out | output | 16 | Instruction register for the decoder |
| bus_obs | output | 16 | Current internal bus value |
| bus_conflict | output | 1 | More than one bus driver enabled |

## Verification
The assertions assume that the control word is stable for a whole cycle and that `mem_rdata` is valid whenever `mem_mfc` is high. They also assume the checks matter only outside reset. The stimulus drives all inputs at the falling edge, so every control word stays settled across the rising edge. Random control words mostly carry zero or one driver, with occasional multi-driver words so that the conflict resolution is exercised. The bench keeps a shadow model of all eleven registers and compares the bus, the memory side and the instruction output in every cycle.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;
    localparam int DATA_W   = 16;
    localparam int GPR_N    = 4;
    localparam int DRV_N    = GPR_N + 4;
    localparam int LD_N     = GPR_N + 7;

    localparam int DRV_PC   = GPR_N;
    localparam int DRV_MDR  = GPR_N + 1;
    localparam int DRV_Z    = GPR_N + 2;
    localparam int DRV_TMP  = GPR_N + 3;

    localparam int LD_PC    = GPR_N;
    localparam int LD_IR    = GPR_N + 1;
    localparam int LD_MAR   = GPR_N + 2;
    localparam int LD_MDR   = GPR_N + 3;
    localparam int LD_Y     = GPR_N + 4;
    localparam int LD_Z     = GPR_N + 5;
    localparam int LD_TMP   = GPR_N + 6;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_XOR   = 2'd2,
        ALU_PASSB = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic [DRV_N-1:0] drv;
        logic [LD_N-1:0]  ld;
        alu_op_e          op;
        logic             cin;
        logic             sel4;
        logic             mdr_ext_in;
        logic             mdr_ext_out;
        logic             rd;
        logic             wr;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sbp_reg.sv
`timescale 1ns/1ps
module sbp_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= d;
    end

    // R4: enabled register captures the value presented at the edge
    a_r4_load_capture: assert property (@(posedge clk) disable iff (rst)
        ld |=> q == $past(d));
    // R4: disabled register keeps its value
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));
endmodule

// File: rtl/sbp_bus_mux.sv
`timescale 1ns/1ps
module sbp_bus_mux #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic [N-1:0][W-1:0] src,
    input  logic [N-1:0]        en,
    output logic [W-1:0]        bus,
    output logic                conflict
);
    always_comb begin
        bus = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en[i]) bus = src[i];
        end
    end

    always_comb begin
        conflict = ($countones(en) > 1);
    end
endmodule

// File: rtl/sbp_alu.sv
`timescale 1ns/1ps
module sbp_alu
    import sbp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         cin,
    output logic [W-1:0] y
);
    logic [W-1:0] cin_w;
    assign cin_w = {{(W-1){1'b0}}, cin};

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b + cin_w;
            ALU_SUB: y = a - b - cin_w;
            ALU_XOR: y = a ^ b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/sbp_mdr.sv
`timescale 1ns/1ps
module sbp_mdr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_d,
    input  logic         ld_bus,
    input  logic [W-1:0] mem_d,
    input  logic         ld_mem,
    input  logic         mfc,
    input  logic         drive_mem,
    output logic [W-1:0] q,
    output logic [W-1:0] mem_q
);
    logic take_mem;
    assign take_mem = ld_mem && mfc;

    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (take_mem) q <= mem_d;
        else if (ld_bus)   q <= bus_d;
    end

    assign mem_q = drive_mem ? q : '0;

    // R8: no capture from memory before completion is signalled
    a_r8_wait_mfc: assert property (@(posedge clk) disable iff (rst)
        (ld_mem && !mfc && !ld_bus) |=> $stable(q));
    // R8: completed read lands in the register
    a_r8_mem_capture: assert property (@(posedge clk) disable iff (rst)
        (ld_mem && mfc) |=> q == $past(mem_d));
    // R9: write lines quiet when not driving
    a_r9_wdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !drive_mem |-> mem_q == '0);
endmodule

// File: rtl/sbp_datapath.sv
`timescale 1ns/1ps
module sbp_datapath
    import sbp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [W-1:0]      mem_rdata,
    input  logic              mem_mfc,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [W-1:0]      ir_out,
    output logic [W-1:0]      bus_obs,
    output logic              bus_conflict
);
    localparam logic [W-1:0] CONST4 = W'(4);

    ctrl_t c;
    assign c = ctrl_t'(ctrl);

    logic [W-1:0] bus;
    logic [W-1:0] gpr_q [GPR_N];
    logic [W-1:0] pc_q, ir_q, mar_q, mdr_q, y_q, z_q, tmp_q;
    logic [W-1:0] alu_a, alu_y;
    logic [DRV_N-1:0][W-1:0] src;

    genvar gi;
    generate
        for (gi = 0; gi < GPR_N; gi++) begin : g_gpr
            sbp_reg #(.W(W)) u_gpr (
                .clk(clk), .rst(rst), .ld(c.ld[gi]), .d(bus), .q(gpr_q[gi])
            );
            assign src[gi] = gpr_q[gi];
        end
    endgenerate

    sbp_reg #(.W(W)) u_pc  (.clk(clk), .rst(rst), .ld(c.ld[LD_PC]),  .d(bus),   .q(pc_q));
    sbp_reg #(.W(W)) u_ir  (.clk(clk), .rst(rst), .ld(c.ld[LD_IR]),  .d(bus),   .q(ir_q));
    sbp_reg #(.W(W)) u_mar (.clk(clk), .rst(rst), .ld(c.ld[LD_MAR]), .d(bus),   .q(mar_q));
    sbp_reg #(.W(W)) u_y   (.clk(clk), .rst(rst), .ld(c.ld[LD_Y]),   .d(bus),   .q(y_q));
    sbp_reg #(.W(W)) u_z   (.clk(clk), .rst(rst), .ld(c.ld[LD_Z]),   .d(alu_y), .q(z_q));
    sbp_reg #(.W(W)) u_tmp (.clk(clk), .rst(rst), .ld(c.ld[LD_TMP]), .d(bus),   .q(tmp_q));

    sbp_mdr #(.W(W)) u_mdr (
        .clk(clk), .rst(rst),
        .bus_d(bus), .ld_bus(c.ld[LD_MDR]),
        .mem_d(mem_rdata), .ld_mem(c.mdr_ext_in), .mfc(mem_mfc),
        .drive_mem(c.mdr_ext_out),
        .q(mdr_q), .mem_q(mem_wdata)
    );

    assign src[DRV_PC]  = pc_q;
    assign src[DRV_MDR] = mdr_q;
    assign src[DRV_Z]   = z_q;
    assign src[DRV_TMP] = tmp_q;

    sbp_bus_mux #(.W(W), .N(DRV_N)) u_bus (
        .src(src), .en(c.drv), .bus(bus), .conflict(bus_conflict)
    );

    assign alu_a = c.sel4 ? CONST4 : y_q;

    sbp_alu #(.W(W)) u_alu (
        .a(alu_a), .b(bus), .op(c.op), .cin(c.cin), .y(alu_y)
    );

    assign mem_addr = mar_q;
    assign mem_rd   = c.rd;
    assign mem_wr   = c.wr;
    assign ir_out   = ir_q;
    assign bus_obs  = bus;

    // R2: an idle bus reads zero
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (c.drv == '0) |-> bus == '0);
    // R3: without a conflict at most one source is enabled
    a_r3_flag_single: assert property (@(posedge clk) disable iff (rst)
        !bus_conflict |-> $countones(c.drv) <= 1);
    // R6: result register changes only on its load enable
    a_r6_z_hold: assert property (@(posedge clk) disable iff (rst)
        !c.ld[LD_Z] |=> $stable(z_q));
    // R7: address lines follow what the address register captured
    a_r7_addr_follow: assert property (@(posedge clk) disable iff (rst)
        c.ld[LD_MAR] |=> mem_addr == $past(bus));
    // R10: instruction output follows instruction register loads
    a_r10_ir_follow: assert property (@(posedge clk) disable iff (rst)
        c.ld[LD_IR] |=> ir_out == $past(bus));
endmodule

// File: tb/sim_sbp_datapath.sv
`timescale 1ns/1ps
module sim_sbp_datapath;
    import sbp_pkg::*;
    localparam int W = DATA_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CTRL_W-1:0] ctrl = '0;
    logic [W-1:0]      mem_rdata = '0;
    logic              mem_mfc = 1'b0;
    logic [W-1:0]      mem_addr, mem_wdata, ir_out, bus_obs;
    logic              mem_rd, mem_wr, bus_conflict;

    always #2.5 clk = ~clk;

    sbp_datapath u0 (
        .clk(clk), .rst(rst), .ctrl(ctrl), .mem_rdata(mem_rdata), .mem_mfc(mem_mfc),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_out(ir_out), .bus_obs(bus_obs), .bus_conflict(bus_conflict)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [W-1:0] s_gpr [GPR_N];
    logic [W-1:0] s_pc, s_ir, s_mar, s_mdr, s_y, s_z, s_tmp;
    logic [W-1:0] last_bus;

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] src_val(input int i);
        if (i < GPR_N) return s_gpr[i];
        case (i - GPR_N)
            0: return s_pc;
            1: return s_mdr;
            2: return s_z;
            default: return s_tmp;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_alu(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [1:0] op, input logic ci);
        logic [W:0] t;
        case (op)
            2'd0: t = {1'b0, a} + {1'b0, b} + (W+1)'(ci);
            2'd1: t = {1'b0, a} - {1'b0, b} - (W+1)'(ci);
            2'd2: t = {1'b0, a ^ b};
            default: t = {1'b0, b};
        endcase
        return t[W-1:0];
    endfunction

    task automatic cyc(input ctrl_t c, input logic mfc, input logic [W-1:0] din);
        logic [W-1:0] eb, ea, ez;
        int nd, first;
        @(negedge clk);
        ctrl = c; mem_mfc = mfc; mem_rdata = din;
        #1;
        nd = 0; first = -1;
        for (int i = 0; i < DRV_N; i++) begin
            if (c.drv[i]) begin
                nd++;
                if (first < 0) first = i;
            end
        end
        eb = (first < 0) ? '0 : src_val(first);
        last_bus = bus_obs;
        if (nd > 1) check(bus_obs == eb, "R3 bus lowest driver", bus_obs, eb);
        else        check(bus_obs == eb, "R2 bus value", bus_obs, eb);
        check(bus_conflict == (nd > 1), "R3 conflict flag", W'(bus_conflict), W'(nd > 1));
        check(mem_addr == s_mar, "R7 address lines", mem_addr, s_mar);
        check(ir_out == s_ir, "R10 ir output", ir_out, s_ir);
        check(mem_wdata == (c.mdr_ext_out ? s_mdr : '0), "R9 write data", mem_wdata,
              c.mdr_ext_out ? s_mdr : '0);
        check({mem_rd, mem_wr} == {c.rd, c.wr}, "R9 strobes", W'({mem_rd, mem_wr}),
              W'({c.rd, c.wr}));
        ea = c.sel4 ? W'(4) : s_y;
        ez = exp_alu(ea, eb, c.op, c.cin);
        for (int i = 0; i < GPR_N; i++) if (c.ld[i]) s_gpr[i] = eb;
        if (c.ld[LD_PC])  s_pc  = eb;
        if (c.ld[LD_IR])  s_ir  = eb;
        if (c.ld[LD_MAR]) s_mar = eb;
        if (c.ld[LD_Y])   s_y   = eb;
        if (c.ld[LD_TMP]) s_tmp = eb;
        if (c.ld[LD_Z])   s_z   = ez;
        if (c.mdr_ext_in && mfc) s_mdr = din;
        else if (c.ld[LD_MDR])   s_mdr = eb;
    endtask

    function automatic ctrl_t idle();
        ctrl_t c;
        c = '0;
        return c;
    endfunction

    task automatic read_src(input int i);
        ctrl_t c;
        c = idle();
        c.drv[i] = 1'b1;
        cyc(c, 1'b0, '0);
    endtask

    task automatic mem_to_gpr(input int r, input logic [W-1:0] v);
        ctrl_t c;
        c = idle(); c.mdr_ext_in = 1'b1; c.rd = 1'b1;
        cyc(c, 1'b1, v);
        c = idle(); c.drv[DRV_MDR] = 1'b1; c.ld[r] = 1'b1;
        cyc(c, 1'b0, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        ctrl_t c;
        logic [W-1:0] keep;
        void'($urandom(32'd1234));
        for (int i = 0; i < GPR_N; i++) s_gpr[i] = '0;
        s_pc = '0; s_ir = '0; s_mar = '0; s_mdr = '0; s_y = '0; s_z = '0; s_tmp = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state visible on bus and address lines
        for (int i = 0; i < DRV_N; i++) begin
            read_src(i);
            check(last_bus == '0, "R1 reset value", last_bus, '0);
        end
        check(mem_addr == '0, "R1 address after reset", mem_addr, '0);

        // R11: three-step add of register 1 and register 2 into register 3
        mem_to_gpr(1, 16'd7);
        mem_to_gpr(2, 16'd9);
        c = idle(); c.drv[1] = 1'b1; c.ld[LD_Y] = 1'b1; cyc(c, 1'b0, '0);
        c = idle(); c.drv[2] = 1'b1; c.op = ALU_ADD; c.ld[LD_Z] = 1'b1; cyc(c, 1'b0, '0);
        c = idle(); c.drv[DRV_Z] = 1'b1; c.ld[3] = 1'b1; cyc(c, 1'b0, '0);
        read_src(3);
        check(last_bus == 16'd16, "R11 sum in register 3", last_bus, 16'd16);

        // R8: data register ignores read data before completion
        keep = s_mdr;
        c = idle(); c.mdr_ext_in = 1'b1; c.rd = 1'b1; cyc(c, 1'b0, 16'hBEEF);
        read_src(DRV_MDR);
        check(last_bus == keep, "R8 no capture without mfc", last_bus, keep);
        // R8: memory capture wins over a bus load in the same cycle
        c = idle(); c.mdr_ext_in = 1'b1; c.drv[1] = 1'b1; c.ld[LD_MDR] = 1'b1;
        cyc(c, 1'b1, 16'hA5A5);
        read_src(DRV_MDR);
        check(last_bus == 16'hA5A5, "R8 memory precedence", last_bus, 16'hA5A5);

        // R5: constant four operand increments the program counter
        c = idle(); c.drv[DRV_PC] = 1'b1; c.ld[LD_MAR] = 1'b1; c.sel4 = 1'b1;
        c.ld[LD_Z] = 1'b1; c.rd = 1'b1; cyc(c, 1'b0, '0);
        c = idle(); c.drv[DRV_Z] = 1'b1; c.ld[LD_PC] = 1'b1; cyc(c, 1'b0, '0);
        read_src(DRV_PC);
        check(last_bus == 16'd4, "R5 constant four", last_bus, 16'd4);

        // R5: subtract with borrow wraps around
        mem_to_gpr(0, 16'd3);
        mem_to_gpr(1, 16'd5);
        c = idle(); c.drv[0] = 1'b1; c.ld[LD_Y] = 1'b1; cyc(c, 1'b0, '0);
        c = idle(); c.drv[1] = 1'b1; c.op = ALU_SUB; c.cin = 1'b1; c.ld[LD_Z] = 1'b1;
        cyc(c, 1'b0, '0);
        // R6: result register holds across cycles without its load enable
        c = idle(); c.drv[1] = 1'b1; c.op = ALU_XOR; cyc(c, 1'b0, '0);
        read_src(DRV_Z);
        check(last_bus == 16'hFFFD, "R5 R6 subtract wrap held", last_bus, 16'hFFFD);

        // R3: two drivers, lowest index wins
        c = idle(); c.drv[1] = 1'b1; c.drv[3] = 1'b1; cyc(c, 1'b0, '0);
        check(last_bus == 16'd5, "R3 conflict resolution", last_bus, 16'd5);

        // R9: write data lines present the data register
        c = idle(); c.mdr_ext_out = 1'b1; c.wr = 1'b1; cyc(c, 1'b0, '0);

        // R4: register loads and holds under random control words
        for (int k = 0; k < 600; k++) begin
            int r;
            c = ctrl_t'($urandom());
            r = $urandom_range(0, 9);
            if (r < 2)      c.drv = '0;
            else if (r < 9) c.drv = DRV_N'(1) << $urandom_range(0, DRV_N - 1);
            cyc(c, 1'($urandom_range(0, 1)), W'($urandom()));
        end
        for (int i = 0; i < DRV_N; i++) read_src(i);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule